// File: doc/BRIEF.md
# Serial-Loaded Drive Control Register

This block takes 16-bit control words from a three-wire serial link (a frame enable, a bit clock and a data line) and holds them in a parallel register whose fields steer a motor-drive controller. All three serial wires are treated as asynchronous. They are resampled on the local system clock, and bits are taken on detected rising edges of the bit clock, most-significant bit first.

A frame closes when the enable falls. The shifted word then moves to the output register only if the frame carried sixteen or more bits. A shorter frame is thrown away. A longer frame leaves the last sixteen bits in the shifter, because the earlier bits have been shifted out. Each load raises a one-cycle strobe. The reset input returns every field to zero.

Top module: `serial_ctrl_reg`

## Requirements
- R1: Bits are taken on rising edges of `ser_clk` while `ser_en` is high. The first bit taken lands in word bit 15 and the sixteenth in bit 0.
- R2: If a frame ends with fewer than 16 bits taken, `cfg_word` keeps its previous value and `upd_stb` stays low.
- R3: If a frame ends with more than 16 bits taken, `cfg_word` holds the last 16 bits received, in transmission order, and the earlier bits are lost.
- R4: While `rst_n` is low at a clock edge, `cfg_word` and every field output become 0 at that edge. A frame that is cut by reset loads nothing.
- R5: The bit count saturates at 16, so frames of 32, 33 or more bits still load.
- R6: Take E1 as the first rising `clk` edge after `ser_en` falls. `cfg_word` changes at edge E4 and is unchanged after E3.
- R7: `upd_stb` is high for exactly the one cycle in which a newly loaded word first appears. It is low at all other times.
- R8: Field outputs decode `cfg_word` by position:
  - bit 0: `f_active`
  - bit 1: `f_vcm_on`
  - bit 2: `f_spin_on`
  - bit 3: `f_brake`
  - bit 4: `f_bemf_sense`
  - bit 5: `f_var_count`
  - bit 6: `f_ext_comm`
  - bit 7: `f_fast_slew`
  - bits 9:8: `f_comm_time`
  - bits 11:10: `f_off_time`
  - bit 12: `f_spin_gain`
  - bit 13: `f_retract`
  - bits 15:14: `f_test`

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset to defaults |
| ser_en | input | 1 | Frame enable, high during a frame |
| ser_clk | input | 1 | Serial bit clock, sampled on rising edges |
| ser_dat | input | 1 | Serial data, MSB first |
| cfg_word | output | 16 | Whole control word |
| upd_stb | output | 1 | One-cycle pulse on each register load |
| f_active | output | 1 | Active (not standby) |
| f_vcm_on | output | 1 | Actuator driver enable |
| f_spin_on | output | 1 | Spindle enable |
| f_brake | output | 1 | Brake enable |
| f_bemf_sense | output | 1 | Back-EMF sensing enable |
| f_var_count | output | 1 | Variable count mode |
| f_ext_comm | output | 1 | External commutation |
| f_fast_slew | output | 1 | High slew rate |
| f_comm_time | output | 2 | Commutation-time select |
| f_off_time | output | 2 | PWM off-time select |
| f_spin_gain | output | 1 | High spindle gain |
| f_retract | output | 1 | Retract request |
| f_test | output | 2 | Test bits |

## Verification
The assertions rely on three properties of the inputs. First, each level of `ser_en`, `ser_clk` and `ser_dat` is held for at least two system clocks. Second, `ser_dat` is steady before the bit clock rises. Third, `ser_en` does not pulse low and high again within one system clock.

The stimulus meets all three by changing signals only on falling clock edges and holding every serial phase for three cycles. It sets data up while the bit clock is low, and it leaves several idle cycles between frames. Within those limits, the bench sweeps:
- frame lengths from zero up to well past 32 bits;
- walking-one words and arithmetically derived words;
- a reset applied in the middle of a frame.

// File: rtl/ctl_pkg.sv
// Package: shared widths and the control-field layout.
// Assumes the field positions are fixed by downstream decode.
package ctl_pkg;
    localparam int WORD_W = 16;

    // Packed layout: the first member sits at bit 15, the last at bit 0.
    typedef struct packed {
        logic [1:0] test;
        logic       retract;
        logic       spin_gain;
        logic [1:0] off_time;
        logic [1:0] comm_time;
        logic       fast_slew;
        logic       ext_comm;
        logic       var_count;
        logic       bemf_sense;
        logic       brake;
        logic       spin_on;
        logic       vcm_on;
        logic       active;
    } ctl_fields_t;
endpackage

// File: rtl/sync_bank.sv
// Module: sync_bank
// Resamples N asynchronous inputs through a chain of STAGES flops each.
// Assumes each input level lasts at least two clk periods.
// Reset clears every stage to 0.
module sync_bank #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d_in,
    output logic [N-1:0] d_out
);
    generate
        for (genvar i = 0; i < N; i++) begin : g_bit
            logic [STAGES-1:0] chain;
            // Purpose: shift the raw input through the flop chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d_in[i]};
            end
            assign d_out[i] = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/frame_rx.sv
// Module: frame_rx
// Detects bit-clock rising edges and the falling edge of the enable on
// already-synchronized inputs. Shifts data in MSB first and counts bits,
// saturating at WIDTH.
// Assumes the inputs come from sync_bank.
module frame_rx #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_s,
    input  logic             sck_s,
    input  logic             dat_s,
    output logic [WIDTH-1:0] shword,
    output logic             frame_end,
    output logic             full
);
    localparam int CNT_W = $clog2(WIDTH + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WIDTH);

    logic             en_q, sck_q;
    logic [CNT_W-1:0] cnt;
    logic             bit_take;

    assign bit_take  = en_s && sck_s && !sck_q;
    assign frame_end = en_q && !en_s;
    assign full      = (cnt == CNT_MAX);

    // Purpose: keep the previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            sck_q <= 1'b0;
        end else begin
            en_q  <= en_s;
            sck_q <= sck_s;
        end
    end

    // Purpose: shift data in MSB first on each detected bit-clock rise.
    always_ff @(posedge clk) begin
        if (!rst_n)        shword <= '0;
        else if (bit_take) shword <= {shword[WIDTH-2:0], dat_s};
    end

    // Purpose: count bits in the frame, saturating, cleared while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_s)         cnt <= '0;
        else if (bit_take && !full)  cnt <= cnt + 1'b1;
    end

    // R5: the count never goes past WIDTH.
    a_r5_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_MAX);
    // R5: a bit taken while full leaves the count full.
    a_r5_cnt_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        (full && bit_take) |=> full);
endmodule

// File: rtl/ctl_reg.sv
// Module: ctl_reg
// Parallel control register. A frame end that carries a full count
// arms a commit flag; the register loads on the next clock and pulses
// the strobe in the same cycle.
// Assumes shword does not change between frame end and load, because
// the enable is low in that window.
module ctl_reg #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_end,
    input  logic             full,
    input  logic [WIDTH-1:0] shword,
    output logic [WIDTH-1:0] word,
    output logic             upd_stb
);
    logic commit_q;

    // Purpose: record that the frame just closed was long enough.
    always_ff @(posedge clk) begin
        if (!rst_n) commit_q <= 1'b0;
        else        commit_q <= frame_end && full;
    end

    // Purpose: load the register and raise the strobe one clock later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word    <= '0;
            upd_stb <= 1'b0;
        end else begin
            upd_stb <= commit_q;
            if (commit_q) word <= shword;
        end
    end

    // R4: reset forces the defaults.
    a_r4_reset_default: assert property (@(posedge clk)
        !rst_n |=> (word == '0));
    // R7: the register only changes together with the strobe.
    a_r7_change_with_stb: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(word) |-> upd_stb);
    // R7: the strobe lasts a single cycle.
    a_r7_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
        upd_stb |=> !upd_stb);
endmodule

// File: rtl/serial_ctrl_reg.sv
// Module: serial_ctrl_reg (top)
// Serial-loaded 16-bit drive control register with field decode.
// Assumes the serial inputs are asynchronous to clk and each level is
// held for at least two clk periods.
module serial_ctrl_reg (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ser_en,
    input  logic        ser_clk,
    input  logic        ser_dat,
    output logic [15:0] cfg_word,
    output logic        upd_stb,
    output logic        f_active,
    output logic        f_vcm_on,
    output logic        f_spin_on,
    output logic        f_brake,
    output logic        f_bemf_sense,
    output logic        f_var_count,
    output logic        f_ext_comm,
    output logic        f_fast_slew,
    output logic [1:0]  f_comm_time,
    output logic [1:0]  f_off_time,
    output logic        f_spin_gain,
    output logic        f_retract,
    output logic [1:0]  f_test
);
    import ctl_pkg::*;

    localparam int SYNC_STAGES = 2;

    logic [2:0]        raw_in, syn;
    logic [WORD_W-1:0] shword, word;
    logic              frame_end, full;
    ctl_fields_t       fld;

    assign raw_in = {ser_en, ser_clk, ser_dat};

    sync_bank #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (raw_in),
        .d_out (syn)
    );

    frame_rx #(.WIDTH(WORD_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_s      (syn[2]),
        .sck_s     (syn[1]),
        .dat_s     (syn[0]),
        .shword    (shword),
        .frame_end (frame_end),
        .full      (full)
    );

    ctl_reg #(.WIDTH(WORD_W)) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_end (frame_end),
        .full      (full),
        .shword    (shword),
        .word      (word),
        .upd_stb   (upd_stb)
    );

    assign cfg_word     = word;
    assign fld          = ctl_fields_t'(word);
    assign f_active     = fld.active;
    assign f_vcm_on     = fld.vcm_on;
    assign f_spin_on    = fld.spin_on;
    assign f_brake      = fld.brake;
    assign f_bemf_sense = fld.bemf_sense;
    assign f_var_count  = fld.var_count;
    assign f_ext_comm   = fld.ext_comm;
    assign f_fast_slew  = fld.fast_slew;
    assign f_comm_time  = fld.comm_time;
    assign f_off_time   = fld.off_time;
    assign f_spin_gain  = fld.spin_gain;
    assign f_retract    = fld.retract;
    assign f_test       = fld.test;

    // R2: a short frame leaves the register as it was, two clocks on.
    a_r2_short_discard: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && !full) |=> ##1 $stable(word));
    // R6: a full frame end produces the strobe exactly two clocks later.
    a_r6_update_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && full) |=> ##1 upd_stb);
endmodule

// File: tb/sim_serial_ctrl_reg.sv
module sim_serial_ctrl_reg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_en = 1'b0, ser_clk = 1'b0, ser_dat = 1'b0;
    logic [15:0] cfg_word;
    logic        upd_stb;
    logic        f_active, f_vcm_on, f_spin_on, f_brake, f_bemf_sense;
    logic        f_var_count, f_ext_comm, f_fast_slew, f_spin_gain, f_retract;
    logic [1:0]  f_comm_time, f_off_time, f_test;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    logic [15:0] model = '0;

    always #2.5 clk = ~clk;

    serial_ctrl_reg u0 (
        .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .ser_clk(ser_clk),
        .ser_dat(ser_dat), .cfg_word(cfg_word), .upd_stb(upd_stb),
        .f_active(f_active), .f_vcm_on(f_vcm_on), .f_spin_on(f_spin_on),
        .f_brake(f_brake), .f_bemf_sense(f_bemf_sense),
        .f_var_count(f_var_count), .f_ext_comm(f_ext_comm),
        .f_fast_slew(f_fast_slew), .f_comm_time(f_comm_time),
        .f_off_time(f_off_time), .f_spin_gain(f_spin_gain),
        .f_retract(f_retract), .f_test(f_test)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // R8: reassemble the field outputs by their stated positions.
    function automatic logic [15:0] fields_word();
        return {f_test, f_retract, f_spin_gain, f_off_time, f_comm_time,
                f_fast_slew, f_ext_comm, f_var_count, f_bemf_sense,
                f_brake, f_spin_on, f_vcm_on, f_active};
    endfunction

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Send the low n bits of v, MSB first, then close the frame and
    // check the load timing (R6), the strobe (R7) and the result.
    task automatic send_frame(input logic [47:0] v, input int n, input string req);
        logic [15:0] old;
        logic [15:0] exp;
        old = model;
        exp = (n >= 16) ? v[15:0] : old;
        @(negedge clk); ser_en = 1'b1; hold(3);
        for (int i = 0; i < n; i++) begin
            ser_dat = v[n-1-i]; ser_clk = 1'b0; hold(3);
            ser_clk = 1'b1; hold(3);
        end
        ser_clk = 1'b0; hold(3);
        ser_en = 1'b0;
        hold(3);                                   // after E3
        chk({"R6 pre-load ", req}, cfg_word, old);
        chk({"R7 no early stb ", req}, {15'd0, upd_stb}, 16'd0);
        hold(1);                                   // after E4
        chk({req, " word"}, cfg_word, exp);
        chk({"R8 fields ", req}, fields_word(), exp);
        chk({"R7 stb ", req}, {15'd0, upd_stb}, {15'd0, n >= 16});
        hold(1);
        chk({"R7 stb drop ", req}, {15'd0, upd_stb}, 16'd0);
        hold(3);
        model = exp;
    endtask

    initial begin
        hold(4);
        rst_n = 1'b1;
        hold(2);
        chk("R4 reset word", cfg_word, 16'h0000);
        chk("R4 reset fields", fields_word(), 16'h0000);
        chk("R7 reset stb", {15'd0, upd_stb}, 16'd0);
        // R1 and R8: walking one over every bit position.
        for (int b = 0; b < 16; b++)
            send_frame(48'(16'h1 << b), 16, "R1 walk");
        // R1: arithmetically derived exact-length words.
        for (int k = 0; k < 24; k++)
            send_frame(48'(k * 40503 + 4660), 16, "R1 word");
        // R2 and R3: length sweep with derived content.
        for (int n = 0; n <= 24; n++) begin
            logic [47:0] v;
            v = 48'(n) * 48'h9E3779B97F4B + 48'h5A5A3C3C1234;
            send_frame(v, n, (n < 16) ? "R2 short" : "R3 long");
        end
        // R5: lengths around and past twice the word size.
        send_frame(48'hA5C3_0F1E_7B29, 31, "R5 len31");
        send_frame(48'h1357_9BDF_2468, 32, "R5 len32");
        send_frame(48'hFEDC_BA98_7654, 33, "R5 len33");
        send_frame(48'h0F0F_F0F0_C33C, 47, "R5 len47");
        // R4: reset in the middle of a frame loads nothing.
        @(negedge clk); ser_en = 1'b1; hold(3);
        for (int i = 0; i < 10; i++) begin
            ser_dat = i[0]; ser_clk = 1'b0; hold(3); ser_clk = 1'b1; hold(3);
        end
        rst_n = 1'b0; hold(2);
        chk("R4 mid-frame reset", cfg_word, 16'h0000);
        rst_n = 1'b1;
        for (int i = 0; i < 8; i++) begin
            ser_dat = 1'b1; ser_clk = 1'b0; hold(3); ser_clk = 1'b1; hold(3);
        end
        ser_clk = 1'b0; hold(3); ser_en = 1'b0; hold(8);
        chk("R4 cut frame not loaded", cfg_word, 16'h0000);
        model = '0;
        send_frame(48'hBEEF, 16, "R4 recovery");
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule